// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry

This block shifts the second operand of a 32-bit data-processing datapath and produces the carry bit that such a shift defines. Each request carries a 32-bit value, a 2-bit shift type, a carry-in bit, and an amount source. The amount source is either a 5-bit immediate or the low byte of a register, and a mode input chooses between them.

A decode stage maps the type and amount to an effective operation and amount. In immediate mode, an immediate of zero has special meanings. For the two right shifts it means a shift by 32. For the rotate type it means a one-bit rotate through the carry. In register mode the amount is taken as given, so it can be 32 or larger.

The shift core applies the operation to the value and computes the result and the carry-out. Both are registered, so a request marked valid appears at the outputs one cycle later. When no valid request arrives, the outputs keep their values.

Top module: `shift_unit`

## Requirements
- R1: The type field selects the operation: 0 is logical left, 1 is logical right, 2 is arithmetic right and 3 is rotate right. In immediate mode with an immediate n from 1 to 31, each type shifts by n.
- R2: In immediate mode, an immediate of 0 with type 1 or type 2 gives a shift amount of 32. Logical right then gives a zero result with carry equal to input bit 31. Arithmetic right gives 32 copies of bit 31 and that bit as the carry.
- R3: In immediate mode, type 3 with an immediate of 0 selects rotate through carry. The result is carry-in at bit 31 and input bits 31..1 below it. The carry-out is input bit 0.
- R4: In register mode, type 3 is always a plain rotate and never a rotate through carry, whatever the amount.
- R5: When the effective amount is 0, the result equals the input and the carry-out equals the carry-in. This covers immediate type 0 with immediate 0, and register mode with an amount of 0 for any type.
- R6: A logical left shift by n from 1 to 31 gives carry-out equal to input bit 32−n.
- R7: Logical right and arithmetic right by n from 1 to 31 give carry-out equal to input bit n−1. Arithmetic right fills the vacated upper bits with copies of input bit 31.
- R8: A rotate right whose amount is nonzero gives carry-out equal to result bit 31.
- R9: In register mode, amounts of 32 and above behave as follows:
  - A logical left shift by 32 gives a zero result with carry equal to input bit 0.
  - A logical right shift by 32 gives a zero result with carry equal to input bit 31.
  - A logical shift above 32 gives a zero result and a zero carry.
  - An arithmetic right shift of 32 or more gives 32 copies of input bit 31, and that bit is also the carry.
- R10: In register mode, a rotate uses the amount modulo 32. A nonzero multiple of 32 leaves the value unchanged and sets carry-out to input bit 31.
- R11: A request with valid_i high appears on result_o and carry_o one clock later, with valid_o high in that cycle. While valid_i is low, valid_o goes low one clock later and result_o and carry_o hold their values.
- R12: While rst_ni is low, result_o, carry_o and valid_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request valid |
| value_i | input | 32 | Operand to shift |
| type_i | input | 2 | Shift type (0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right) |
| reg_mode_i | input | 1 | 1: amount comes from amt_reg_i; 0: amount comes from imm_i |
| imm_i | input | 5 | Immediate shift amount |
| amt_reg_i | input | 8 | Register shift amount (low byte of a register) |
| carry_i | input | 1 | Carry-in |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | Shifted result |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The hardest cases to reach from the ports are the amounts of 32 and above, because only register mode can produce them. Within that mode, the boundary values 32 and 33 and the rotate multiples 64 and 96 matter most. The immediate-zero encodings turn those same cases into different operations, so the bench drives identical values through both modes and through the neighbouring amounts 1, 31, 32 and 33. It also compares every request against a bit-by-bit model built from the requirements. The hold behaviour is reached by dropping valid_i while the other inputs change.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [2:0] {
    SH_LSL,
    SH_LSR,
    SH_ASR,
    SH_ROR,
    SH_RRX
  } sh_op_e;

  localparam logic [1:0] TY_LSL = 2'd0;
  localparam logic [1:0] TY_LSR = 2'd1;
  localparam logic [1:0] TY_ASR = 2'd2;
  localparam logic [1:0] TY_ROR = 2'd3;
endpackage

// File: rtl/shift_decode.sv
module shift_decode
  import shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 5,
  parameter int AMT_W  = 8
) (
  input  logic [1:0]       type_i,
  input  logic             reg_mode_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [AMT_W-1:0] amt_reg_i,
  output sh_op_e           op_o,
  output logic [AMT_W-1:0] amt_o
);
  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

  logic [AMT_W-1:0] imm_ext;
  logic             imm_zero;

  assign imm_ext  = AMT_W'(imm_i);
  assign imm_zero = (imm_i == '0);

  always_comb begin
    op_o  = SH_LSL;
    amt_o = imm_ext;
    if (reg_mode_i) begin
      amt_o = amt_reg_i;
      unique case (type_i)
        TY_LSL:  op_o = SH_LSL;
        TY_LSR:  op_o = SH_LSR;
        TY_ASR:  op_o = SH_ASR;
        default: op_o = SH_ROR;
      endcase
    end else begin
      unique case (type_i)
        TY_LSL: op_o = SH_LSL;
        TY_LSR: begin
          op_o  = SH_LSR;
          amt_o = imm_zero ? FULL_AMT : imm_ext;
        end
        TY_ASR: begin
          op_o  = SH_ASR;
          amt_o = imm_zero ? FULL_AMT : imm_ext;
        end
        default: begin
          op_o  = imm_zero ? SH_RRX : SH_ROR;
          amt_o = imm_zero ? AMT_W'(1) : imm_ext;
        end
      endcase
    end
  end
endmodule

// File: rtl/shift_core.sv
module shift_core
  import shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] value_i,
  input  sh_op_e            op_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  localparam int SH_W = $clog2(DATA_W);

  // One guard bit beside the data holds the bit shifted out last
  logic [DATA_W:0]        lsl_x;
  logic [DATA_W:0]        lsr_x;
  logic signed [DATA_W:0] asr_x;
  logic [SH_W-1:0]        rot_m;
  logic [DATA_W-1:0]      rot_r;

  assign lsl_x = {1'b0, value_i} << amt_i;
  assign lsr_x = {value_i, 1'b0} >> amt_i;
  assign asr_x = $signed({value_i, 1'b0}) >>> amt_i;
  assign rot_m = amt_i[SH_W-1:0];
  assign rot_r = (value_i >> rot_m) | (value_i << (DATA_W - int'(rot_m)));

  always_comb begin
    result_o = value_i;
    carry_o  = carry_i;
    if (op_i == SH_RRX) begin
      result_o = {carry_i, value_i[DATA_W-1:1]};
      carry_o  = value_i[0];
    end else if (amt_i != '0) begin
      unique case (op_i)
        SH_LSL: begin
          result_o = lsl_x[DATA_W-1:0];
          carry_o  = lsl_x[DATA_W];
        end
        SH_LSR: begin
          result_o = lsr_x[DATA_W:1];
          carry_o  = lsr_x[0];
        end
        SH_ASR: begin
          result_o = asr_x[DATA_W:1];
          carry_o  = asr_x[0];
        end
        default: begin
          result_o = rot_r;
          carry_o  = rot_r[DATA_W-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 5,
  parameter int AMT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] value_i,
  input  logic [1:0]        type_i,
  input  logic              reg_mode_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [AMT_W-1:0]  amt_reg_i,
  input  logic              carry_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  sh_op_e            dec_op;
  logic [AMT_W-1:0]  dec_amt;
  logic [DATA_W-1:0] core_res;
  logic              core_c;

  shift_decode #(.DATA_W(DATA_W), .IMM_W(IMM_W), .AMT_W(AMT_W)) u_dec (
    .type_i    (type_i),
    .reg_mode_i(reg_mode_i),
    .imm_i     (imm_i),
    .amt_reg_i (amt_reg_i),
    .op_o      (dec_op),
    .amt_o     (dec_amt)
  );

  shift_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
    .value_i (value_i),
    .op_i    (dec_op),
    .amt_i   (dec_amt),
    .carry_i (carry_i),
    .result_o(core_res),
    .carry_o (core_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      carry_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= core_res;
        carry_o  <= core_c;
      end
    end
  end
endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 5,
  parameter int AMT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] value_i,
  input logic [1:0]        type_i,
  input logic              reg_mode_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic [AMT_W-1:0]  amt_reg_i,
  input logic              carry_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              carry_o
);
  // R11
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o) && $stable(carry_o)));

  // R3
  rrx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !reg_mode_i && type_i == 2'd3 && imm_i == '0) |=>
      (result_o == {$past(carry_i), $past(value_i[DATA_W-1:1])} && carry_o == $past(value_i[0])));

  // R5
  zero_amt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ((reg_mode_i && amt_reg_i == '0) || (!reg_mode_i && type_i == 2'd0 && imm_i == '0))) |=>
      (result_o == $past(value_i) && carry_o == $past(carry_i)));

  // R9
  lsl_over_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && reg_mode_i && type_i == 2'd0 && amt_reg_i > AMT_W'(DATA_W)) |=>
      (result_o == '0 && !carry_o));

  // R8
  ror_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && type_i == 2'd3 && ((reg_mode_i && amt_reg_i != '0) || (!reg_mode_i && imm_i != '0))) |=>
      (carry_o == result_o[DATA_W-1]));

  // R12
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_clear_chk: assert (!valid_o && result_o == '0 && !carry_o);
    end
  end
endmodule

bind shift_unit shift_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .AMT_W(AMT_W)) u_chk (.*);

// File: tb/shift_unit_tb.sv
`timescale 1ns/1ps
module shift_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] value_i = '0;
  logic [1:0]  type_i = '0;
  logic        reg_mode_i = 1'b0;
  logic [4:0]  imm_i = '0;
  logic [7:0]  amt_reg_i = '0;
  logic        carry_i = 1'b0;
  logic        valid_o;
  logic [31:0] result_o;
  logic        carry_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  shift_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .value_i(value_i),
    .type_i(type_i), .reg_mode_i(reg_mode_i), .imm_i(imm_i), .amt_reg_i(amt_reg_i),
    .carry_i(carry_i), .valid_o(valid_o), .result_o(result_o), .carry_o(carry_o)
  );

  // Bit-by-bit model written from the requirements
  task automatic model(input logic [31:0] v, input logic [1:0] t, input logic rm,
                       input logic [4:0] imm, input logic [7:0] ar, input logic ci,
                       output logic [31:0] r, output logic c);
    int  n;
    bit  rrx;
    n   = rm ? int'(ar) : int'(imm);
    rrx = 1'b0;
    if (!rm && imm == 0 && (t == 2'd1 || t == 2'd2)) n = 32;
    if (!rm && imm == 0 && t == 2'd3) rrx = 1'b1;
    r = v;
    c = ci;
    if (rrx) begin
      for (int i = 0; i < 31; i++) r[i] = v[i+1];
      r[31] = ci;
      c = v[0];
    end else if (n != 0) begin
      case (t)
        2'd0: begin
          for (int i = 0; i < 32; i++) r[i] = (i - n >= 0) ? v[i-n] : 1'b0;
          c = (n <= 32) ? v[32-n] : 1'b0;
        end
        2'd1: begin
          for (int i = 0; i < 32; i++) r[i] = (i + n <= 31) ? v[i+n] : 1'b0;
          c = (n <= 32) ? v[n-1] : 1'b0;
        end
        2'd2: begin
          for (int i = 0; i < 32; i++) r[i] = (i + n <= 31) ? v[i+n] : v[31];
          c = (n <= 32) ? v[n-1] : v[31];
        end
        default: begin
          for (int i = 0; i < 32; i++) r[i] = v[(i + n) % 32];
          c = r[31];
        end
      endcase
    end
  endtask

  task automatic check(input string req, input logic [31:0] er, input logic ec);
    tests++;
    if (result_o !== er || carry_o !== ec || valid_o !== 1'b1) begin
      fails++;
      $display("FAIL %s: act res=%h c=%b v=%b exp res=%h c=%b v=1",
               req, result_o, carry_o, valid_o, er, ec);
    end
  endtask

  // Drive one request, compare against the model and an optional fixed value
  task automatic run(input string req, input logic [31:0] v, input logic [1:0] t,
                     input logic rm, input logic [4:0] imm, input logic [7:0] ar,
                     input logic ci);
    logic [31:0] er;
    logic        ec;
    model(v, t, rm, imm, ar, ci, er, ec);
    @(negedge clk);
    valid_i = 1'b1; value_i = v; type_i = t; reg_mode_i = rm;
    imm_i = imm; amt_reg_i = ar; carry_i = ci;
    @(negedge clk);
    check(req, er, ec);
  endtask

  task automatic run_fixed(input string req, input logic [31:0] v, input logic [1:0] t,
                           input logic rm, input logic [4:0] imm, input logic [7:0] ar,
                           input logic ci, input logic [31:0] er, input logic ec);
    @(negedge clk);
    valid_i = 1'b1; value_i = v; type_i = t; reg_mode_i = rm;
    imm_i = imm; amt_reg_i = ar; carry_i = ci;
    @(negedge clk);
    check(req, er, ec);
  endtask

  task automatic t_reset;
    tests++;
    if (valid_o !== 1'b0 || result_o !== '0 || carry_o !== 1'b0) begin
      fails++;
      $display("FAIL R12: act v=%b res=%h c=%b exp v=0 res=0 c=0", valid_o, result_o, carry_o);
    end
  endtask

  task automatic t_imm_basic;
    for (int ty = 0; ty < 4; ty++) begin
      run("R1", 32'h9234_5679, 2'(ty), 1'b0, 5'd4, 8'd0, 1'b0);
      run("R1", 32'h8000_0001, 2'(ty), 1'b0, 5'd31, 8'd0, 1'b1);
    end
    run_fixed("R1", 32'h0000_00F0, 2'd1, 1'b0, 5'd4, 8'd0, 1'b0, 32'h0000_000F, 1'b0);
  endtask

  task automatic t_imm_zero_right;
    run_fixed("R2", 32'h8000_0000, 2'd1, 1'b0, 5'd0, 8'd0, 1'b0, 32'h0, 1'b1);
    run_fixed("R2", 32'h8000_0000, 2'd2, 1'b0, 5'd0, 8'd0, 1'b0, 32'hFFFF_FFFF, 1'b1);
    run_fixed("R2", 32'h7FFF_FFFF, 2'd2, 1'b0, 5'd0, 8'd0, 1'b1, 32'h0, 1'b0);
  endtask

  task automatic t_rrx;
    run_fixed("R3", 32'h0000_0001, 2'd3, 1'b0, 5'd0, 8'd0, 1'b1, 32'h8000_0000, 1'b1);
    run_fixed("R3", 32'hFFFF_FFFE, 2'd3, 1'b0, 5'd0, 8'd0, 1'b0, 32'h7FFF_FFFF, 1'b0);
  endtask

  task automatic t_reg_ror;
    run_fixed("R4", 32'h1234_5678, 2'd3, 1'b1, 5'd0, 8'd1, 1'b1, 32'h091A_2B3C, 1'b0);
    run_fixed("R4", 32'h0000_0003, 2'd3, 1'b1, 5'd0, 8'd1, 1'b0, 32'h8000_0001, 1'b1);
  endtask

  task automatic t_zero;
    run_fixed("R5", 32'hCAFE_F00D, 2'd0, 1'b0, 5'd0, 8'd0, 1'b1, 32'hCAFE_F00D, 1'b1);
    for (int ty = 0; ty < 4; ty++)
      run_fixed("R5", 32'h1357_9BDF, 2'(ty), 1'b1, 5'd7, 8'd0, 1'b0, 32'h1357_9BDF, 1'b0);
  endtask

  task automatic t_lsl_carry;
    run_fixed("R6", 32'h4000_0000, 2'd0, 1'b0, 5'd2, 8'd0, 1'b0, 32'h0, 1'b1);
    run_fixed("R6", 32'h0000_0002, 2'd0, 1'b0, 5'd31, 8'd0, 1'b0, 32'h0, 1'b1);
    for (int n = 1; n < 32; n++) run("R6", 32'hA5C3_0F69, 2'd0, 1'b0, 5'(n), 8'd0, 1'b0);
  endtask

  task automatic t_right_carry;
    run_fixed("R7", 32'h8000_0004, 2'd2, 1'b0, 5'd3, 8'd0, 1'b0, 32'hF000_0000, 1'b1);
    for (int n = 1; n < 32; n++) begin
      run("R7", 32'hA5C3_0F69, 2'd1, 1'b0, 5'(n), 8'd0, 1'b1);
      run("R7", 32'hA5C3_0F69, 2'd2, 1'b0, 5'(n), 8'd0, 1'b1);
    end
  endtask

  task automatic t_ror_carry;
    run_fixed("R8", 32'h0000_0010, 2'd3, 1'b0, 5'd5, 8'd0, 1'b0, 32'h8000_0000, 1'b1);
    for (int n = 1; n < 32; n++) run("R8", 32'h6B1D_E402, 2'd3, 1'b0, 5'(n), 8'd0, 1'b0);
  endtask

  task automatic t_reg_large;
    run_fixed("R9", 32'h0000_0001, 2'd0, 1'b1, 5'd0, 8'd32, 1'b0, 32'h0, 1'b1);
    run_fixed("R9", 32'hFFFF_FFFF, 2'd0, 1'b1, 5'd0, 8'd33, 1'b1, 32'h0, 1'b0);
    run_fixed("R9", 32'h8000_0000, 2'd1, 1'b1, 5'd0, 8'd32, 1'b0, 32'h0, 1'b1);
    run_fixed("R9", 32'hFFFF_FFFF, 2'd1, 1'b1, 5'd0, 8'd33, 1'b1, 32'h0, 1'b0);
    run_fixed("R9", 32'h8000_0000, 2'd2, 1'b1, 5'd0, 8'd200, 1'b0, 32'hFFFF_FFFF, 1'b1);
    run_fixed("R9", 32'h7FFF_FFFF, 2'd2, 1'b1, 5'd0, 8'd32, 1'b1, 32'h0, 1'b0);
    for (int a = 30; a < 36; a++)
      for (int ty = 0; ty < 3; ty++) run("R9", 32'hC001_D00D, 2'(ty), 1'b1, 5'd0, 8'(a), 1'b0);
  endtask

  task automatic t_reg_rot_mod;
    run_fixed("R10", 32'h8765_4321, 2'd3, 1'b1, 5'd0, 8'd32, 1'b0, 32'h8765_4321, 1'b1);
    run_fixed("R10", 32'h0765_4321, 2'd3, 1'b1, 5'd0, 8'd64, 1'b1, 32'h0765_4321, 1'b0);
    run_fixed("R10", 32'h0000_0001, 2'd3, 1'b1, 5'd0, 8'd97, 1'b0, 32'h8000_0000, 1'b1);
    for (int a = 0; a < 256; a += 7) run("R10", 32'h5A0F_3C96, 2'd3, 1'b1, 5'd0, 8'(a), 1'b1);
  endtask

  task automatic t_hold;
    run_fixed("R11", 32'h0000_00FF, 2'd0, 1'b0, 5'd4, 8'd0, 1'b0, 32'h0000_0FF0, 1'b0);
    @(negedge clk);
    valid_i = 1'b0; value_i = 32'hFFFF_FFFF; type_i = 2'd1; imm_i = 5'd1; carry_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    tests++;
    if (valid_o !== 1'b0 || result_o !== 32'h0000_0FF0 || carry_o !== 1'b0) begin
      fails++;
      $display("FAIL R11: act v=%b res=%h c=%b exp v=0 res=00000ff0 c=0", valid_o, result_o, carry_o);
    end
  endtask

  task automatic t_reset_mid;
    run_fixed("R12", 32'hFFFF_FFFF, 2'd3, 1'b0, 5'd0, 8'd0, 1'b1, 32'hFFFF_FFFF, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_imm_basic();
    t_imm_zero_right();
    t_rrx();
    t_reg_ror();
    t_zero();
    t_lsl_carry();
    t_right_carry();
    t_ror_carry();
    t_reg_large();
    t_reg_rot_mod();
    t_hold();
    t_reset_mid();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R11: watchdog act=hung exp=complete");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule